// File: doc/BRIEF.md
# Stack Processor Microcoded ALU

A purely combinational 32-bit arithmetic and logic unit for a microcoded stack machine. Each microinstruction presents two operands, a 4-bit operation code, a flag that says whether an immediate value is being built up, and a 2-bit shift mode. The unit returns one 32-bit result in the same cycle. The sequencer decides which register takes the result.

Besides the usual pass, add and bitwise operations, the unit provides four functions for the stack machine. The first adds a 5-bit packed stack offset whose top bit is stored inverted. The second builds immediates 7 bits at a time. The third is a pair of subtract-compares whose bit 31 gives the true ordering even when the subtraction overflows. The fourth is a barrel shifter whose direction and kind come from a separate mode input.

Top module: `stk_alu`

## Requirements
- R1: Op 0 returns a. Op 1 returns b. The unused ops 12 to 15 return a.
- R2: Op 2 returns a + b modulo 2^32.
- R3: Op 3 returns a plus a 5-bit offset taken from b. The offset's bit 4 is the inverse of b[4] and its bits 3:0 are b[3:0]. Bits 31:5 of b have no effect.
- R4: Op 4 returns a AND b, op 5 returns a OR b, and op 6 returns NOT a.
- R5: Op 7 returns a with its bit order reversed, so that result bit i equals a bit 31-i.
- R6: Op 8 with the immediate flag at 0 returns b[6:0] sign-extended from bit 6.
- R7: Op 8 with the immediate flag at 1 returns a[24:0] in bits 31:7 and b[6:0] in bits 6:0.
- R8: Op 9 returns a-b in bits 30:0. Bit 31 is 1 exactly when a < b as unsigned numbers.
- R9: Op 10 returns a-b in bits 30:0. Bit 31 is 1 exactly when a < b as two's-complement numbers.
- R10: Op 11 with shift mode 0 returns a shifted left by b[4:0], with zeros filling from the right.
- R11: Op 11 with shift mode 1 returns a shifted right logically by b[4:0].
- R12: Op 11 with shift mode 2 returns a shifted right arithmetically by b[4:0], with a[31] filling from the left.
- R13: Op 11 with shift mode 3, or with a shift amount of 0, returns a.
- R14: Bits 31:5 of b have no effect on op 11. The shift mode and the immediate flag have no effect on any op other than 11 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, offset field, immediate bits or shift amount |
| op_i | input | 4 | Operation code |
| imm_cont_i | input | 1 | An immediate is being built (accumulate instead of sign-extend) |
| shift_mode_i | input | 2 | 0 = left logical, 1 = right logical, 2 = right arithmetic, 3 = no shift |
| result_o | output | 32 | Result |

## Verification
Every function is computed in every cycle, and only the op code chooses which one is seen. The risk is that a side input meant for one function, such as the shift mode or the immediate flag, reaches another function. The bench therefore drives a random shift mode and a random immediate flag with every op. It compares each result against a model that depends on those inputs only for ops 11 and 8. Directed vectors then place a compare overflow and a sign-fill shift on the same operand corners (0x7FFFFFFF, 0x80000000), so that both are checked on identical inputs.

// File: rtl/stk_alu_pkg.sv
`timescale 1ns/1ps
package stk_alu_pkg;

  typedef enum logic [3:0] {
    OP_PASS_A  = 4'd0,
    OP_PASS_B  = 4'd1,
    OP_ADD     = 4'd2,
    OP_ADD_OFS = 4'd3,
    OP_AND     = 4'd4,
    OP_OR      = 4'd5,
    OP_NOT     = 4'd6,
    OP_REV     = 4'd7,
    OP_IMM     = 4'd8,
    OP_CMP_U   = 4'd9,
    OP_CMP_S   = 4'd10,
    OP_SHIFT   = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2,
    SH_NONE  = 2'd3
  } shift_mode_e;

endpackage

// File: rtl/stk_alu_logic.sv
`timescale 1ns/1ps
module stk_alu_logic #(
  parameter int WIDTH    = 32,
  parameter int OFS_BITS = 5
) (
  input  logic [WIDTH-1:0]    a_i,
  input  logic [WIDTH-1:0]    b_i,
  input  logic [OFS_BITS-1:0] ofs_i,
  output logic [WIDTH-1:0]    add_o,
  output logic [WIDTH-1:0]    ofs_sum_o,
  output logic [WIDTH-1:0]    and_o,
  output logic [WIDTH-1:0]    or_o,
  output logic [WIDTH-1:0]    not_o,
  output logic [WIDTH-1:0]    rev_o
);

  localparam int PAD = WIDTH - OFS_BITS;

  logic [WIDTH-1:0] ofs_ext;

  // top bit of the packed offset is stored inverted
  assign ofs_ext = {{PAD{1'b0}}, ~ofs_i[OFS_BITS-1], ofs_i[OFS_BITS-2:0]};

  always_comb begin
    add_o     = a_i + b_i;
    ofs_sum_o = a_i + ofs_ext;
    and_o     = a_i & b_i;
    or_o      = a_i | b_i;
    not_o     = ~a_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_o[i] = a_i[WIDTH-1-i];
  end

endmodule

// File: rtl/stk_alu_imm.sv
`timescale 1ns/1ps
module stk_alu_imm #(
  parameter int WIDTH    = 32,
  parameter int IMM_BITS = 7
) (
  input  logic [WIDTH-IMM_BITS-1:0] a_low_i,
  input  logic [IMM_BITS-1:0]       chunk_i,
  input  logic                      cont_i,
  output logic [WIDTH-1:0]          imm_o
);

  localparam int EXT = WIDTH - IMM_BITS;

  always_comb begin
    if (cont_i) begin
      imm_o = {a_low_i, chunk_i};
    end else begin
      imm_o = {{EXT{chunk_i[IMM_BITS-1]}}, chunk_i};
    end
  end

endmodule

// File: rtl/stk_alu_cmp.sv
`timescale 1ns/1ps
module stk_alu_cmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] cmp_u_o,
  output logic [WIDTH-1:0] cmp_s_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] diff_ext;
  logic           borrow;
  logic           ovf;
  logic           lt_s;

  always_comb begin
    diff_ext = {1'b0, a_i} - {1'b0, b_i};
    borrow   = diff_ext[WIDTH];
    ovf      = (a_i[MSB] ^ b_i[MSB]) & (diff_ext[MSB] ^ a_i[MSB]);
    lt_s     = diff_ext[MSB] ^ ovf;
    cmp_u_o  = {borrow, diff_ext[MSB-1:0]};
    cmp_s_o  = {lt_s,   diff_ext[MSB-1:0]};
  end

endmodule

// File: rtl/stk_alu_shift.sv
`timescale 1ns/1ps
module stk_alu_shift
  import stk_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_BITS = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]    a_i,
  input  logic [AMT_BITS-1:0] amt_i,
  input  logic [1:0]          mode_i,
  output logic [WIDTH-1:0]    sh_o
);

  logic [WIDTH-1:0] a_rev;
  logic [WIDTH-1:0] core_in;
  logic [WIDTH-1:0] core_out;
  logic [WIDTH-1:0] core_rev;
  logic             left;
  logic             fill;
  logic [AMT_BITS:0][WIDTH-1:0] stg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign a_rev[i]    = a_i[WIDTH-1-i];
    assign core_rev[i] = core_out[WIDTH-1-i];
  end

  // left shifts reuse the right shifter on reversed data
  always_comb begin
    left    = (mode_i == SH_LEFT);
    fill    = (mode_i == SH_ARITH) & a_i[WIDTH-1];
    core_in = left ? a_rev : a_i;
  end

  assign stg[0] = core_in;

  for (genvar s = 0; s < AMT_BITS; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{SH{fill}}, stg[s][WIDTH-1:SH]} : stg[s];
  end

  assign core_out = stg[AMT_BITS];

  always_comb begin
    unique case (mode_i)
      SH_LEFT:  sh_o = core_rev;
      SH_RIGHT: sh_o = core_out;
      SH_ARITH: sh_o = core_out;
      default:  sh_o = a_i;
    endcase
  end

endmodule

// File: rtl/stk_alu.sv
`timescale 1ns/1ps
module stk_alu
  import stk_alu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int IMM_BITS = 7,
  parameter int OFS_BITS = 5
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  input  logic             imm_cont_i,
  input  logic [1:0]       shift_mode_i,
  output logic [WIDTH-1:0] result_o
);

  localparam int AMT_BITS = $clog2(WIDTH);

  logic [WIDTH-1:0] add_r, ofs_r, and_r, or_r, not_r, rev_r;
  logic [WIDTH-1:0] imm_r, cmpu_r, cmps_r, sh_r;

  stk_alu_logic #(.WIDTH(WIDTH), .OFS_BITS(OFS_BITS)) u_logic (
    .a_i       (a_i),
    .b_i       (b_i),
    .ofs_i     (b_i[OFS_BITS-1:0]),
    .add_o     (add_r),
    .ofs_sum_o (ofs_r),
    .and_o     (and_r),
    .or_o      (or_r),
    .not_o     (not_r),
    .rev_o     (rev_r)
  );

  stk_alu_imm #(.WIDTH(WIDTH), .IMM_BITS(IMM_BITS)) u_imm (
    .a_low_i (a_i[WIDTH-IMM_BITS-1:0]),
    .chunk_i (b_i[IMM_BITS-1:0]),
    .cont_i  (imm_cont_i),
    .imm_o   (imm_r)
  );

  stk_alu_cmp #(.WIDTH(WIDTH)) u_cmp (
    .a_i     (a_i),
    .b_i     (b_i),
    .cmp_u_o (cmpu_r),
    .cmp_s_o (cmps_r)
  );

  stk_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i    (a_i),
    .amt_i  (b_i[AMT_BITS-1:0]),
    .mode_i (shift_mode_i),
    .sh_o   (sh_r)
  );

  always_comb begin
    case (op_i)
      OP_PASS_A:  result_o = a_i;
      OP_PASS_B:  result_o = b_i;
      OP_ADD:     result_o = add_r;
      OP_ADD_OFS: result_o = ofs_r;
      OP_AND:     result_o = and_r;
      OP_OR:      result_o = or_r;
      OP_NOT:     result_o = not_r;
      OP_REV:     result_o = rev_r;
      OP_IMM:     result_o = imm_r;
      OP_CMP_U:   result_o = cmpu_r;
      OP_CMP_S:   result_o = cmps_r;
      OP_SHIFT:   result_o = sh_r;
      default:    result_o = a_i;
    endcase
  end

endmodule

// File: rtl/stk_alu_chk.sv
`timescale 1ns/1ps
module stk_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       op_i,
  input logic             imm_cont_i,
  input logic [1:0]       shift_mode_i,
  input logic [WIDTH-1:0] result_o
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    p_pass_a_r1: assert (op_i != 4'd0 || result_o == a_i);
    p_add_inverse_r2: assert (op_i != 4'd2 || (result_o - b_i) == a_i);
    p_not_disjoint_r4: assert (op_i != 4'd6 ||
                               ((result_o & a_i) == '0 && (result_o | a_i) == '1));
    p_rev_ends_r5: assert (op_i != 4'd7 ||
                           (result_o[0] == a_i[MSB] && result_o[MSB] == a_i[0]));
    p_imm_sext_r6: assert (op_i != 4'd8 || imm_cont_i ||
                           result_o[MSB:6] == {(WIDTH-6){b_i[6]}});
    p_ucmp_sign_r8: assert (op_i != 4'd9 || result_o[MSB] == (a_i < b_i));
    p_scmp_sign_r9: assert (op_i != 4'd10 ||
                            result_o[MSB] == ($signed(a_i) < $signed(b_i)));
    p_shift_idle_r13: assert (op_i != 4'd11 ||
                              !(shift_mode_i == 2'd3 || b_i[4:0] == 5'd0) ||
                              result_o == a_i);
  end

endmodule

bind stk_alu stk_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/stk_alu_tb.sv
`timescale 1ns/1ps
module stk_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] a, b, res;
  logic [3:0]  op;
  logic        imm;
  logic [1:0]  mode;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;
  logic [31:0] rng = 32'h2545F491;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  stk_alu u_dut (
    .a_i(a), .b_i(b), .op_i(op), .imm_cont_i(imm),
    .shift_mode_i(mode), .result_o(res)
  );

  function automatic logic [31:0] model(logic [31:0] x, logic [31:0] y,
                                        logic [3:0] o, logic f, logic [1:0] m);
    logic [31:0] r, d;
    d = x - y;
    case (o)
      4'd1: r = y;
      4'd2: r = x + y;
      4'd3: r = x + {27'd0, ~y[4], y[3:0]};
      4'd4: r = x & y;
      4'd5: r = x | y;
      4'd6: r = ~x;
      4'd7: for (int i = 0; i < 32; i++) r[i] = x[31-i];
      4'd8: r = f ? ((x << 7) | {25'd0, y[6:0]}) : {{25{y[6]}}, y[6:0]};
      4'd9: r = {x < y, d[30:0]};
      4'd10: r = {$signed(x) < $signed(y), d[30:0]};
      4'd11: case (m)
        2'd0: r = x << y[4:0];
        2'd1: r = x >> y[4:0];
        2'd2: r = $unsigned($signed(x) >>> y[4:0]);
        default: r = x;
      endcase
      default: r = x;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] o, logic f, logic [1:0] m);
    case (o)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4, 4'd5, 4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return f ? "R7" : "R6";
      4'd9: return "R8";
      4'd10: return "R9";
      4'd11: case (m)
        2'd0: return "R10";
        2'd1: return "R11";
        2'd2: return "R12";
        default: return "R13";
      endcase
      default: return "R1";
    endcase
  endfunction

  task automatic drive(logic [31:0] x, logic [31:0] y, logic [3:0] o,
                       logic f, logic [1:0] m, string t);
    @(posedge clk);
    a = x; b = y; op = o; imm = f; mode = m;
    q.push_back('{model(x, y, o, f, m), t});
  endtask

  task automatic drive_exp(logic [31:0] x, logic [31:0] y, logic [3:0] o,
                           logic f, logic [1:0] m, logic [31:0] e, string t);
    @(posedge clk);
    a = x; b = y; op = o; imm = f; mode = m;
    q.push_back('{e, t});
  endtask

  function automatic logic [31:0] nxt();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  // monitor: sample between driving edges
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (res !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, res, it.exp);
      end
    end
  end

  logic [31:0] corners [4] = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; op = '0; imm = 1'b0; mode = '0;
    drive_exp(0, 0, 0, 0, 0, 32'h0, "R1 reset");
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // directed, hand-computed values
    drive_exp(32'hDEADBEEF, 32'h1, 4'd13, 1, 3, 32'hDEADBEEF, "R1 unused");
    drive_exp(32'hFFFFFFFF, 32'h2, 4'd2, 1, 3, 32'h1, "R2 wrap R14");
    drive_exp(100, 32'h10, 4'd3, 0, 0, 100, "R3 ofs0");
    drive_exp(100, 32'hFFFFFF00, 4'd3, 0, 0, 116, "R3 ofs16 R14");
    drive_exp(100, 32'h1F, 4'd3, 0, 0, 115, "R3 ofs15");
    drive_exp(32'h00000001, 0, 4'd7, 0, 0, 32'h80000000, "R5");
    drive_exp(0, 32'h40, 4'd8, 0, 0, 32'hFFFFFFC0, "R6");
    drive_exp(0, 32'hFFFFFF3F, 4'd8, 0, 0, 32'h0000003F, "R6 upper b");
    drive_exp(32'h00000003, 32'h85, 4'd8, 1, 0, 32'h00000185, "R7");
    drive_exp(0, 1, 4'd9, 0, 0, 32'hFFFFFFFF, "R8 borrow");
    drive_exp(32'h80000000, 1, 4'd9, 0, 0, 32'h7FFFFFFF, "R8 no borrow");
    drive_exp(32'h80000000, 1, 4'd10, 0, 0, 32'hFFFFFFFF, "R9 overflow");
    drive_exp(32'h7FFFFFFF, 32'hFFFFFFFF, 4'd10, 0, 0, 32'h00000000, "R9 overflow");
    drive_exp(32'h80000001, 4, 4'd11, 0, 0, 32'h00000010, "R10");
    drive_exp(32'h80000000, 31, 4'd11, 0, 1, 32'h00000001, "R11");
    drive_exp(32'h80000000, 31, 4'd11, 0, 2, 32'hFFFFFFFF, "R12");
    drive_exp(32'h40000000, 4, 4'd11, 0, 2, 32'h04000000, "R12 pos");
    drive_exp(32'h12345678, 7, 4'd11, 0, 3, 32'h12345678, "R13 mode3");
    drive_exp(32'h12345678, 32'hFFFFFFE0, 4'd11, 0, 2, 32'h12345678, "R13 R14 amt0");
    drive_exp(32'h00000001, 32'h00000121, 4'd11, 0, 0, 32'h00000002, "R14 amt mask");

    // corner sweep, side inputs randomised (R14)
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          logic [31:0] r;
          r = nxt();
          drive(corners[i], corners[j], o[3:0], r[0], r[2:1], tag_of(o[3:0], r[0], r[2:1]));
        end

    // random operands
    for (int k = 0; k < 600; k++) begin
      logic [31:0] x, y, r;
      x = nxt(); y = nxt(); r = nxt();
      drive(x, y, r[3:0], r[4], r[6:5], tag_of(r[3:0], r[4], r[6:5]));
    end

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule